// File: doc/BRIEF.md
# Serial NOR Flash Read Sequencer

This block is the clock-and-select master for pulling data out of a single serial NOR flash device on a four-wire SPI link. A host hands it a 24-bit start address and a byte count through a valid/ready request port. The block then performs the whole access without further help. It first opens a frame that polls the device status until the flash reports it is no longer busy. It then sends a write-disable command in a frame of its own. Finally it opens a read frame and passes every returned byte to the host through a valid/ready data port.

The serial clock runs in mode 0 and is derived from the system clock by a parameter. A second parameter selects between the plain read command and the faster variant, which needs one extra dummy byte after the address. While the status is polled, the block also checks that the write-latch and protection bits are clear, and it raises a flag if they are not. The host can stall the data port at any time. The serial clock then waits between bytes, so no data is lost.

Top module: `spinor_read_top`

## Requirements
- R1: Every accepted request produces exactly three chip-select frames in this order: a status poll frame starting with opcode 0x05, a write-disable frame, and a read frame.
- R2: The read frame begins with opcode 0x0B followed by one dummy byte after the address when FAST_READ=1, and with opcode 0x03 and no dummy byte when FAST_READ=0.
- R3: The read address follows the opcode as three bytes, bits 23:16 first and bits 7:0 last.
- R4: The status poll keeps clocking status bytes in the same frame until a status byte with bit 0 equal to 0 is received. The filler 0xA5 is transmitted on MOSI during every status byte and every dummy or data byte.
- R5: The write-disable frame carries only the single byte 0x04.
- R6: prot_err is 1 after a request whose final status byte has any of bits 5:1 set, is 0 when those bits are clear (bits 7:6 are ignored), and is cleared when the next request is accepted.
- R7: SCK idles low whenever chip select is high. MOSI never changes while SCK is high, and MISO is sampled on the rising SCK edge.
- R8: Chip select stays low for the whole read frame, and rd_valid is only asserted inside it. Chip select rises in the cycle after the last requested byte is taken. The byte count is req_len_m1+1, so values from 1 to 2^24 are possible, and the bytes are delivered in address order.
- R9: One SCK period is 2*CLK_DIV system clocks, and chip select stays high for at least CS_GAP (at least 2) SCK periods between frames.
- R10: While rd_valid is high and rd_ready is low, rd_data holds its value and SCK stays low.
- R11: req_ready is 1 after reset and whenever the block is idle, and it is 0 from acceptance until the read frame ends. Chip select is high whenever req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a read request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | 24 | Start byte address |
| req_len_m1 | input | CNT_W | Number of bytes to read minus one |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Host takes the byte |
| prot_err | output | 1 | Unexpected write-latch or protection bits seen during the poll |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bound checker watches the signalling rules on every cycle. It checks that SCK stays low when chip select is high, that MOSI holds while SCK is high, that a stalled byte holds with the clock parked low, that the gap between frames is long enough, and that chip select is released whenever the block reports idle. The frame contents can only be shown by the bench scenarios, against a flash model that records each frame: the frame order, the opcodes, the address byte order, the dummy byte, the filler value, the number of poll repetitions, the protection flag and the returned data.

// File: rtl/spinor_pkg.sv
package spinor_pkg;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] OP_WDIS    = 8'h04;
  localparam logic [7:0] OP_RD_SLOW = 8'h03;
  localparam logic [7:0] OP_RD_FAST = 8'h0B;
  localparam logic [7:0] FILLER     = 8'hA5;

  localparam int SR_BUSY_BIT = 0;
  localparam int SR_GUARD_LO = 1;
  localparam int SR_GUARD_HI = 5;

  localparam int ADDR_W = 24;

  typedef enum logic [1:0] {FR_POLL, FR_WDIS, FR_READ} frame_e;
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_XFER, ST_HOLD} seq_state_e;
endpackage

// File: rtl/spinor_shifter.sv
module spinor_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DLAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] dcnt;
  logic [2:0]    bcnt;
  logic [7:0]    sh;
  logic          act;
  logic          tick;

  assign tick = act && (dcnt == DLAST);

  // Mode 0: MOSI set while SCK low, MISO taken on the rising edge,
  // next bit shifted on the falling edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt <= '0;
      bcnt <= '0;
      sh   <= '0;
      act  <= 1'b0;
      sck  <= 1'b0;
      mosi <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
    end else begin
      done <= 1'b0;
      if (go && !act) begin
        act  <= 1'b1;
        dcnt <= '0;
        bcnt <= '0;
        sh   <= tx;
        mosi <= tx[7];
        sck  <= 1'b0;
      end else if (act) begin
        if (tick) begin
          dcnt <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bcnt == 3'd7) begin
              act  <= 1'b0;
              done <= 1'b1;
            end else begin
              bcnt <= bcnt + 3'd1;
              sh   <= {sh[6:0], 1'b0};
              mosi <= sh[6];
            end
          end
        end else begin
          dcnt <= dcnt + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spinor_stat_dec.sv
module spinor_stat_dec
  import spinor_pkg::*;
(
  input  logic [7:0] status,
  output logic       busy,
  output logic       fault
);
  assign busy  = status[SR_BUSY_BIT];
  assign fault = |status[SR_GUARD_HI:SR_GUARD_LO];
endmodule

// File: rtl/spinor_seq.sv
module spinor_seq
  import spinor_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int CS_GAP    = 2,
  parameter bit FAST_READ = 1'b1,
  parameter int CNT_W     = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_len_m1,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              prot_err,
  output logic              cs_n,
  output logic              x_go,
  output logic [7:0]        x_tx,
  input  logic              x_done,
  input  logic [7:0]        x_rx,
  input  logic              st_busy,
  input  logic              st_fault
);
  localparam int HDR       = FAST_READ ? 5 : 4;
  localparam int GAP_CYC   = CS_GAP * 2 * CLK_DIV;
  localparam int GW        = $clog2(GAP_CYC + 1);
  localparam logic [7:0] RD_OP = FAST_READ ? OP_RD_FAST : OP_RD_SLOW;
  localparam logic [2:0] HDR_IDX = 3'(HDR);

  seq_state_e        state;
  frame_e            frame;
  logic [2:0]        idx;
  logic [2:0]        idx_inc;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [GW-1:0]     gcnt;

  function automatic logic [7:0] byte_for(frame_e f, logic [2:0] i,
                                          logic [ADDR_W-1:0] a);
    case (f)
      FR_POLL: return (i == 3'd0) ? OP_STATUS : FILLER;
      FR_WDIS: return OP_WDIS;
      default: begin
        case (i)
          3'd0:    return RD_OP;
          3'd1:    return a[23:16];
          3'd2:    return a[15:8];
          3'd3:    return a[7:0];
          default: return FILLER;
        endcase
      end
    endcase
  endfunction

  assign idx_inc = (idx == HDR_IDX) ? idx : idx + 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      frame     <= FR_POLL;
      idx       <= '0;
      addr_q    <= '0;
      left_q    <= '0;
      gcnt      <= '0;
      req_ready <= 1'b1;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      prot_err  <= 1'b0;
      cs_n      <= 1'b1;
      x_go      <= 1'b0;
      x_tx      <= '0;
    end else begin
      x_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q    <= req_addr;
            left_q    <= req_len_m1;
            req_ready <= 1'b0;
            prot_err  <= 1'b0;
            frame     <= FR_POLL;
            gcnt      <= '0;
            state     <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) begin
            cs_n  <= 1'b0;
            idx   <= '0;
            x_tx  <= byte_for(frame, 3'd0, addr_q);
            x_go  <= 1'b1;
            state <= ST_XFER;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
        ST_XFER: begin
          if (x_done) begin
            case (frame)
              FR_POLL: begin
                if (idx == 3'd0 || st_busy) begin
                  idx  <= idx_inc;
                  x_tx <= byte_for(frame, idx_inc, addr_q);
                  x_go <= 1'b1;
                end else begin
                  prot_err <= st_fault;
                  cs_n     <= 1'b1;
                  frame    <= FR_WDIS;
                  gcnt     <= '0;
                  state    <= ST_GAP;
                end
              end
              FR_WDIS: begin
                cs_n  <= 1'b1;
                frame <= FR_READ;
                gcnt  <= '0;
                state <= ST_GAP;
              end
              default: begin
                if (idx != HDR_IDX) begin
                  idx  <= idx_inc;
                  x_tx <= byte_for(frame, idx_inc, addr_q);
                  x_go <= 1'b1;
                end else begin
                  rd_data  <= x_rx;
                  rd_valid <= 1'b1;
                  state    <= ST_HOLD;
                end
              end
            endcase
          end
        end
        default: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            if (left_q == '0) begin
              cs_n      <= 1'b1;
              req_ready <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              left_q <= left_q - CNT_W'(1);
              x_tx   <= FILLER;
              x_go   <= 1'b1;
              state  <= ST_XFER;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spinor_read_top.sv
module spinor_read_top #(
  parameter int CLK_DIV   = 2,
  parameter int CS_GAP    = 2,
  parameter bit FAST_READ = 1'b1,
  parameter int CNT_W     = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [CNT_W-1:0] req_len_m1,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             prot_err,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  logic       x_go;
  logic       x_done;
  logic [7:0] x_tx;
  logic [7:0] x_rx;
  logic       st_busy;
  logic       st_fault;

  spinor_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .go(x_go), .tx(x_tx), .done(x_done), .rx(x_rx),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  spinor_stat_dec u_dec (
    .status(x_rx), .busy(st_busy), .fault(st_fault)
  );

  spinor_seq #(
    .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .FAST_READ(FAST_READ), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len_m1(req_len_m1),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .prot_err(prot_err), .cs_n(spi_cs_n),
    .x_go(x_go), .x_tx(x_tx), .x_done(x_done), .x_rx(x_rx),
    .st_busy(st_busy), .st_fault(st_fault)
  );
endmodule

// File: rtl/spinor_read_chk.sv
module spinor_read_chk #(
  parameter int CLK_DIV = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  hi_cnt <= '0;
    else if (!spi_cs_n)       hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  assert_sck_idle_R7: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> $stable(spi_mosi));

  assert_hold_data_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_clock_parked_R10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !spi_sck);

  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (hi_cnt >= 16'(4 * CLK_DIV)));

  assert_idle_deselect_R11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> spi_cs_n);

  assert_valid_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !spi_cs_n);
endmodule

bind spinor_read_top spinor_read_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_data(rd_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .spi_cs_n(spi_cs_n),
  .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/spinor_read_top_bench.sv
module spinor_flash_model #(
  parameter bit FAST = 1'b1
) (
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       log_clr,
  input  int         busy_cfg,
  input  logic [7:0] stat_cfg,
  output logic       miso
);
  localparam int DSTART = FAST ? 5 : 4;

  int          bitn, byten, busy_left, nframes, bad_fill;
  logic [7:0]  shin, shout, opcode, nxt;
  logic [23:0] addr;
  int          frame_op[8];
  int          frame_len[8];
  logic [23:0] frame_addr[8];
  realtime     t_rise, t_up, min_per, min_gap;
  bit          have_rise, have_up;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  initial begin
    miso = 1'b0; nframes = 0; bad_fill = 0; bitn = 0; byten = 0;
    min_per = 1.0e9; min_gap = 1.0e9; have_up = 0; have_rise = 0;
    shin = '0; shout = '0; opcode = '0; nxt = '0; addr = '0; busy_left = 0;
  end

  always @(posedge log_clr) begin
    nframes = 0; bad_fill = 0; min_per = 1.0e9; min_gap = 1.0e9;
  end

  always @(negedge cs_n) begin
    bitn = 0; byten = 0; busy_left = busy_cfg; miso = 1'b0; have_rise = 0;
    if (have_up && ($realtime - t_up) < min_gap) min_gap = $realtime - t_up;
  end

  always @(posedge cs_n) begin
    if (nframes < 8) begin
      frame_op[nframes]   = int'(opcode);
      frame_len[nframes]  = byten;
      frame_addr[nframes] = addr;
    end
    nframes = nframes + 1;
    t_up = $realtime; have_up = 1;
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      if (have_rise && ($realtime - t_rise) < min_per) min_per = $realtime - t_rise;
      t_rise = $realtime; have_rise = 1;
      shin = {shin[6:0], mosi};
      bitn = bitn + 1;
      if (bitn == 8) begin
        bitn = 0;
        if (byten == 0) opcode = shin;
        else if (opcode == 8'h05) begin
          if (shin != 8'hA5) bad_fill = bad_fill + 1;
        end else if (opcode == 8'h03 || opcode == 8'h0B) begin
          if (byten <= 3) addr = {addr[15:0], shin};
          else if (byten >= DSTART && shin != 8'hA5) bad_fill = bad_fill + 1;
        end
        if (opcode == 8'h05) begin
          if (busy_left > 0) begin
            busy_left = busy_left - 1;
            nxt = stat_cfg | 8'h01;
          end else nxt = stat_cfg & 8'hFE;
        end else if (byten + 1 >= DSTART) nxt = pat(addr + 24'(byten + 1 - DSTART));
        else nxt = 8'h00;
        byten = byten + 1;
      end
    end
  end

  always @(negedge sck) begin
    if (!cs_n) begin
      if (bitn == 0) shout = nxt;
      else shout = {shout[6:0], 1'b0};
      miso = shout[7];
    end
  end
endmodule

module spinor_read_top_bench;
  localparam int CLK_DIV = 2;
  localparam int CS_GAP  = 2;
  localparam realtime TCLK = 8.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [23:0] req_addr = '0, req_len_m1 = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, rd_ready = 1'b0, prot_err;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;
  logic        log_clr = 1'b0;
  int          busy_cfg = 0;
  logic [7:0]  stat_cfg = 8'h00;

  logic        s_req_valid = 1'b0, s_req_ready;
  logic [23:0] s_req_addr = '0, s_req_len_m1 = '0;
  logic [7:0]  s_rd_data;
  logic        s_rd_valid, s_prot_err;
  logic        s_cs_n, s_sck, s_mosi, s_miso;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  spinor_read_top #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .FAST_READ(1'b1)) u_spinor_read_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len_m1(req_len_m1), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .prot_err(prot_err),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  spinor_flash_model #(.FAST(1'b1)) u_flash (
    .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi), .log_clr(log_clr),
    .busy_cfg(busy_cfg), .stat_cfg(stat_cfg), .miso(spi_miso)
  );

  spinor_read_top #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .FAST_READ(1'b0)) u_spinor_read_top_slow (
    .clk(clk), .rst(rst), .req_valid(s_req_valid), .req_ready(s_req_ready),
    .req_addr(s_req_addr), .req_len_m1(s_req_len_m1), .rd_data(s_rd_data),
    .rd_valid(s_rd_valid), .rd_ready(1'b1), .prot_err(s_prot_err),
    .spi_cs_n(s_cs_n), .spi_sck(s_sck), .spi_mosi(s_mosi), .spi_miso(s_miso)
  );

  spinor_flash_model #(.FAST(1'b0)) u_flash_slow (
    .cs_n(s_cs_n), .sck(s_sck), .mosi(s_mosi), .log_clr(log_clr),
    .busy_cfg(1), .stat_cfg(8'h00), .miso(s_miso)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp,
                     input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  // Issues one request on the fast instance and collects n bytes.
  task automatic run_read(input logic [23:0] a, input int n, input int stall, input string tag);
    int got, wd, bad_data, bad_stall, bad_cs;
    logic [7:0] held;
    got = 0; wd = 0; bad_data = 0; bad_stall = 0; bad_cs = 0;
    clear_log();
    @(negedge clk);
    req_addr = a; req_len_m1 = 24'(n - 1); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", req_ready, 0, {tag, " ready low while busy"});
    while (got < n && wd < 40000) begin
      @(negedge clk); wd++;
      if (rd_valid) begin
        if (stall > 0 && (got % 2) == 1) begin
          held = rd_data;
          repeat (stall) begin
            @(negedge clk);
            if (!(rd_valid && rd_data == held && !spi_sck)) bad_stall++;
          end
        end
        if (rd_data != pat(a + 24'(got))) bad_data++;
        if (spi_cs_n) bad_cs++;
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        got++;
      end
    end
    chk(got == n, "R8", got, n, {tag, " byte count"});
    chk(bad_data == 0, "R8", bad_data, 0, {tag, " data mismatches"});
    chk(bad_cs == 0 && spi_cs_n == 1'b1, "R8", bad_cs, 0, {tag, " cs held then released"});
    chk(req_ready == 1'b1, "R11", req_ready, 1, {tag, " ready after frame"});
    if (stall > 0) chk(bad_stall == 0, "R10", bad_stall, 0, {tag, " stall holds"});
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11", req_ready, 1, "reset ready");
    chk(spi_cs_n == 1'b1, "R8", spi_cs_n, 1, "reset cs");
    chk(spi_sck == 1'b0, "R7", spi_sck, 0, "reset sck");
    chk(rd_valid == 1'b0, "R8", rd_valid, 0, "reset valid");
  endtask

  task automatic t_basic();
    busy_cfg = 0; stat_cfg = 8'h00;
    run_read(24'h123456, 4, 0, "basic");
    chk(u_flash.nframes == 3, "R1", u_flash.nframes, 3, "frame count");
    chk(u_flash.frame_op[0] == 8'h05, "R1", u_flash.frame_op[0], 8'h05, "poll opcode");
    chk(u_flash.frame_len[0] == 2, "R4", u_flash.frame_len[0], 2, "poll length idle");
    chk(u_flash.frame_op[1] == 8'h04 && u_flash.frame_len[1] == 1, "R5",
        u_flash.frame_op[1], 8'h04, "write-disable frame");
    chk(u_flash.frame_op[2] == 8'h0B, "R2", u_flash.frame_op[2], 8'h0B, "fast opcode");
    chk(u_flash.frame_len[2] == 9, "R2", u_flash.frame_len[2], 9, "fast frame with dummy");
    chk(u_flash.frame_addr[2] == 24'h123456, "R3", u_flash.frame_addr[2], 24'h123456, "address order");
    chk(u_flash.bad_fill == 0, "R4", u_flash.bad_fill, 0, "filler bytes");
    chk(prot_err == 1'b0, "R6", prot_err, 0, "no fault");
  endtask

  task automatic t_busy();
    busy_cfg = 3; stat_cfg = 8'h00;
    run_read(24'h00A000, 3, 0, "busy");
    chk(u_flash.frame_len[0] == 5, "R4", u_flash.frame_len[0], 5, "poll repeats while busy");
    chk(u_flash.frame_op[1] == 8'h04, "R1", u_flash.frame_op[1], 8'h04, "order after poll");
    chk(u_flash.bad_fill == 0, "R4", u_flash.bad_fill, 0, "filler during poll");
    busy_cfg = 0;
  endtask

  task automatic t_single();
    run_read(24'hFFFFFF, 1, 0, "single");
    chk(u_flash.frame_len[2] == 6, "R8", u_flash.frame_len[2], 6, "one-byte frame length");
  endtask

  task automatic t_stall();
    run_read(24'h0400F0, 6, 7, "stall");
    chk(u_flash.frame_len[2] == 11, "R10", u_flash.frame_len[2], 11, "no extra bytes under stall");
  endtask

  task automatic t_fault();
    stat_cfg = 8'h02;
    run_read(24'h000010, 2, 0, "wel");
    chk(prot_err == 1'b1, "R6", prot_err, 1, "latch bit flagged");
    stat_cfg = 8'h3C;
    run_read(24'h000020, 2, 0, "bp");
    chk(prot_err == 1'b1, "R6", prot_err, 1, "protect bits flagged");
    stat_cfg = 8'hC0;
    run_read(24'h000030, 2, 0, "upper");
    chk(prot_err == 1'b0, "R6", prot_err, 0, "bits 7:6 ignored and flag cleared");
    stat_cfg = 8'h00;
  endtask

  task automatic t_timing();
    run_read(24'h777777, 3, 0, "timing");
    chk(u_flash.min_per == 2.0 * CLK_DIV * TCLK, "R9", longint'(u_flash.min_per),
        longint'(2.0 * CLK_DIV * TCLK), "sck period");
    chk(u_flash.min_gap >= 2.0 * 2.0 * CLK_DIV * TCLK, "R9", longint'(u_flash.min_gap),
        longint'(4.0 * CLK_DIV * TCLK), "cs gap");
  endtask

  task automatic t_slow();
    int got, wd, bad;
    got = 0; wd = 0; bad = 0;
    clear_log();
    @(negedge clk);
    s_req_addr = 24'hABCDEF; s_req_len_m1 = 24'd4; s_req_valid = 1'b1;
    @(negedge clk);
    s_req_valid = 1'b0;
    while (got < 5 && wd < 40000) begin
      @(negedge clk); wd++;
      if (s_rd_valid) begin
        if (s_rd_data != pat(24'hABCDEF + 24'(got))) bad++;
        got++;
      end
    end
    @(negedge clk);
    chk(got == 5 && bad == 0, "R2", bad, 0, "slow read data");
    chk(u_flash_slow.frame_op[2] == 8'h03, "R2", u_flash_slow.frame_op[2], 8'h03, "slow opcode");
    chk(u_flash_slow.frame_len[2] == 9, "R2", u_flash_slow.frame_len[2], 9, "slow frame without dummy");
    chk(u_flash_slow.frame_addr[2] == 24'hABCDEF, "R3", u_flash_slow.frame_addr[2], 24'hABCDEF, "slow address");
    chk(u_flash_slow.frame_len[0] == 3, "R4", u_flash_slow.frame_len[0], 3, "slow poll once busy");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy();
    t_single();
    t_stall();
    t_fault();
    t_timing();
    t_slow();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule